// File: doc/BRIEF.md
# Run-Length Sample Compressor and Packet Framer

This block accepts a stream of fixed-width logic-analyser samples and folds runs of identical consecutive samples into compact entries. Each entry holds the sample value followed by a repeat count. The entries are serialised into a byte stream that is grouped into transfer packets. Every packet holds a fixed number of entries and closes with a sequence byte. The packets are further grouped into chunks of a fixed packet count. A trigger marker that comes with a sample makes that sample start a fresh entry, so the trigger position lies on an entry boundary. The block latches how many packets and entries went out before the entry that holds the trigger.

A flush request ends a capture. Any open entry is closed, and the stream is then padded with empty entries until the last packet and the last chunk are complete. Downstream storage or transport takes the bytes through a valid/ready handshake. When the internal entry queue is full or a flush is in progress, the block holds off new samples with an input ready signal.

Top module: `rle_packetizer`

## Requirements
- R1: Each entry goes out as SAMPLE_W/8 value bytes, least significant byte first, followed by one count byte (16-bit default: value[7:0], value[15:8], count).
- R2: An entry closes when an accepted sample differs from the open run's value. Its count byte equals the number of consecutive accepted samples that held that value.
- R3: A run that reaches 255 samples (2**RUN_W-1) closes. The next equal sample starts a new entry with count 1.
- R4: A data entry never carries a count of 0. Count 0 appears only in padding entries.
- R5: After every ENTRIES_PER_PKT entries, one sequence byte is sent. The first sequence byte after reset is 0, and each later one is the previous plus 1, modulo 256.
- R6: An accepted sample with trig_mark high closes the open entry, even if the value is unchanged, and starts a new entry with count 1.
- R7: When the first trigger-flagged entry is sent, trig_seen rises. At that point pre_trig_pkts latches the number of whole packets already sent, and pre_trig_entries latches the number of data entries already sent. Later triggers leave both values unchanged.
- R8: A flush_req accepted while in_ready is high closes the open entry. It then appends padding entries (all bytes 0) until the packet total is a multiple of PKTS_PER_CHUNK and no packet is partly filled. A flush that finds the stream already aligned adds no padding.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_data keeps its value.
- R10: in_ready is low in the cycle after a flush is accepted and whenever the entry queue is full. A sample or flush presented while in_ready is low is not taken.
- R11: After reset, out_valid is 0, in_ready is 1, trig_seen is 0, and all four counters are 0.
- R12: pkt_count equals the number of sequence bytes sent. entry_count equals the number of data entries sent, not counting padding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample present |
| smp_data | input | SAMPLE_W | Sample value |
| trig_mark | input | 1 | The sample offered with this high is the trigger sample |
| flush_req | input | 1 | End of capture; close and pad the stream |
| in_ready | output | 1 | Sample and flush are taken in this cycle |
| out_data | output | 8 | Output byte |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Consumer takes the byte |
| trig_seen | output | 1 | The trigger entry has been sent |
| pre_trig_pkts | output | CNT_W | Whole packets sent before the trigger entry |
| pre_trig_entries | output | CNT_W | Data entries sent before the trigger entry |
| pkt_count | output | CNT_W | Packets sent since reset |
| entry_count | output | CNT_W | Data entries sent since reset |

## Verification
The assertions check the following on every cycle:
- the output byte is held under back-pressure;
- no data entry with count zero enters the queue;
- the queue never receives a push while full;
- a flush always drops in_ready;
- padding ends only on a chunk boundary;
- the trigger latches stay frozen once set.

The byte layout, run lengths and the 255 split are shown only by the scoreboard scenarios, which compare every output byte against a model. The same applies to forced closure on a trigger, the exact pre-trigger counts, padding length versus an already aligned flush, and the sequence numbering.

// File: rtl/rle_pkg.sv
package rle_pkg;
   typedef enum logic [1:0] {
      FL_IDLE  = 2'd0,
      FL_CLOSE = 2'd1,
      FL_MARK  = 2'd2
   } flush_st_t;

   function automatic int bits_for(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/rle_run_encoder.sv
module rle_run_encoder
   import rle_pkg::*;
#(
   parameter int SAMPLE_W = 16,
   parameter int RUN_W    = 8,
   parameter int EW       = SAMPLE_W + RUN_W + 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                smp_valid,
   input  logic [SAMPLE_W-1:0] smp_data,
   input  logic                trig_mark,
   input  logic                flush_req,
   input  logic                fifo_full,
   output logic                in_ready,
   output logic                push,
   output logic [EW-1:0]       push_entry
);
   localparam int MARK_BIT = RUN_W + SAMPLE_W;
   localparam int TRIG_BIT = MARK_BIT + 1;
   localparam logic [RUN_W-1:0] RUN_MAX = '1;
   localparam logic [RUN_W-1:0] RUN_ONE = RUN_W'(1);

   logic                run_open;
   logic                run_trig;
   logic [SAMPLE_W-1:0] run_val;
   logic [RUN_W-1:0]    run_cnt;
   flush_st_t           fl_st;
   logic                take;
   logic                flush_go;
   logic                brk;
   logic [EW-1:0]       run_entry;
   logic [EW-1:0]       mark_entry;

   assign in_ready   = (fl_st == FL_IDLE) && !fifo_full;
   assign take       = smp_valid && in_ready;
   assign flush_go   = flush_req && in_ready;
   assign brk        = run_open && ((smp_data != run_val) || (run_cnt == RUN_MAX) || trig_mark);
   assign run_entry  = {run_trig, 1'b0, run_val, run_cnt};
   assign mark_entry = {1'b0, 1'b1, {(SAMPLE_W + RUN_W){1'b0}}};

   always_comb begin
      push       = 1'b0;
      push_entry = run_entry;
      if (take && brk) begin
         push = 1'b1;
      end else if (fl_st == FL_CLOSE && !fifo_full) begin
         push       = 1'b1;
         push_entry = run_open ? run_entry : mark_entry;
      end else if (fl_st == FL_MARK && !fifo_full) begin
         push       = 1'b1;
         push_entry = mark_entry;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_open <= 1'b0;
         run_trig <= 1'b0;
         run_val  <= '0;
         run_cnt  <= '0;
         fl_st    <= FL_IDLE;
      end else begin
         if (take) begin
            if (!run_open || brk) begin
               run_open <= 1'b1;
               run_val  <= smp_data;
               run_cnt  <= RUN_ONE;
               run_trig <= trig_mark;
            end else begin
               run_cnt <= run_cnt + RUN_ONE;
            end
         end
         case (fl_st)
            FL_IDLE: if (flush_go) fl_st <= FL_CLOSE;
            FL_CLOSE: if (!fifo_full) begin
               if (run_open) begin
                  run_open <= 1'b0;
                  fl_st    <= FL_MARK;
               end else begin
                  fl_st <= FL_IDLE;
               end
            end
            FL_MARK: if (!fifo_full) fl_st <= FL_IDLE;
            default: fl_st <= FL_IDLE;
         endcase
      end
   end

   // R4: a data entry entering the queue always carries a non-zero count
   assert_no_zero_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !push_entry[MARK_BIT]) |-> (push_entry[RUN_W-1:0] != '0));

   // R10: an accepted flush stalls the sample input on the next cycle
   assert_flush_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flush_go |=> !in_ready);

   // R6: a trigger-flagged entry never carries the marker flag
   assert_trig_not_mark_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (push && push_entry[TRIG_BIT]) |-> !push_entry[MARK_BIT]);
endmodule

// File: rtl/rle_entry_fifo.sv
module rle_entry_fifo #(
   parameter int EW    = 26,
   parameter int DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [EW-1:0] push_entry,
   input  logic          pop,
   output logic [EW-1:0] head,
   output logic          empty,
   output logic          full
);
   localparam int AW = rle_pkg::bits_for(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [AW-1:0] A_LAST = AW'(DEPTH - 1);
   localparam logic [AW-1:0] A_ONE  = AW'(1);
   localparam logic [CW-1:0] C_FULL = CW'(DEPTH);
   localparam logic [CW-1:0] C_ONE  = CW'(1);

   logic [EW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0] fill;

   if (DEPTH < 2) begin : g_depth_chk
      $error("rle_entry_fifo: DEPTH must be at least 2");
   end

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_ptr + A_ONE;
      assign rd_nxt = rd_ptr + A_ONE;
   end else begin : g_wrap
      assign wr_nxt = (wr_ptr == A_LAST) ? '0 : wr_ptr + A_ONE;
      assign rd_nxt = (rd_ptr == A_LAST) ? '0 : rd_ptr + A_ONE;
   end

   assign empty = (fill == '0);
   assign full  = (fill == C_FULL);
   assign head  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= push_entry;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         if (push && !pop)      fill <= fill + C_ONE;
         else if (pop && !push) fill <= fill - C_ONE;
      end
   end

   // R10: the encoder never writes into a full queue
   assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);

   // R10: the framer never reads an empty queue
   assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/rle_byte_framer.sv
module rle_byte_framer #(
   parameter int SAMPLE_W        = 16,
   parameter int RUN_W           = 8,
   parameter int EW              = SAMPLE_W + RUN_W + 2,
   parameter int ENTRIES_PER_PKT = 5,
   parameter int PKTS_PER_CHUNK  = 5,
   parameter int CNT_W           = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EW-1:0]    head,
   input  logic             fifo_empty,
   output logic             pop,
   output logic [7:0]       out_data,
   output logic             out_valid,
   input  logic             out_ready,
   output logic             trig_seen,
   output logic [CNT_W-1:0] pre_trig_pkts,
   output logic [CNT_W-1:0] pre_trig_entries,
   output logic [CNT_W-1:0] pkt_count,
   output logic [CNT_W-1:0] entry_count
);
   localparam int VB       = SAMPLE_W / 8;
   localparam int EB       = VB + 1;
   localparam int BW       = rle_pkg::bits_for(EB);
   localparam int EIW      = $clog2(ENTRIES_PER_PKT + 1);
   localparam int PIW      = rle_pkg::bits_for(PKTS_PER_CHUNK);
   localparam int MARK_BIT = RUN_W + SAMPLE_W;
   localparam int TRIG_BIT = MARK_BIT + 1;
   localparam logic [BW-1:0]  B_LAST = BW'(EB - 1);
   localparam logic [BW-1:0]  B_ONE  = BW'(1);
   localparam logic [EIW-1:0] E_SEQ  = EIW'(ENTRIES_PER_PKT);
   localparam logic [EIW-1:0] E_ONE  = EIW'(1);
   localparam logic [PIW-1:0] P_LAST = PIW'(PKTS_PER_CHUNK - 1);
   localparam logic [PIW-1:0] P_ONE  = PIW'(1);
   localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);

   logic [7:0]     ent_bytes [EB];
   logic [BW-1:0]  b_idx;
   logic [EIW-1:0] e_idx;
   logic [PIW-1:0] p_idx;
   logic [7:0]     seq;
   logic           padding;
   logic           seq_slot;
   logic           head_data;
   logic           head_mark;
   logic           fire;

   for (genvar g = 0; g < VB; g++) begin : g_val_bytes
      assign ent_bytes[g] = head[RUN_W + 8*g +: 8];
   end
   if (RUN_W == 8) begin : g_cnt_full
      assign ent_bytes[VB] = head[7:0];
   end else begin : g_cnt_ext
      assign ent_bytes[VB] = {{(8 - RUN_W){1'b0}}, head[RUN_W-1:0]};
   end

   assign seq_slot  = (e_idx == E_SEQ);
   assign head_data = !fifo_empty && !head[MARK_BIT];
   assign head_mark = !fifo_empty && head[MARK_BIT];

   always_comb begin
      out_valid = 1'b0;
      out_data  = 8'h00;
      if (seq_slot) begin
         out_valid = 1'b1;
         out_data  = seq;
      end else if (padding) begin
         out_valid = 1'b1;
      end else if (head_data) begin
         out_valid = 1'b1;
         out_data  = ent_bytes[b_idx];
      end
   end

   assign fire = out_valid && out_ready;
   assign pop  = !seq_slot && !padding &&
                 ((head_data && fire && (b_idx == B_LAST)) || head_mark);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         b_idx            <= '0;
         e_idx            <= '0;
         p_idx            <= '0;
         seq              <= '0;
         padding          <= 1'b0;
         trig_seen        <= 1'b0;
         pre_trig_pkts    <= '0;
         pre_trig_entries <= '0;
         pkt_count        <= '0;
         entry_count      <= '0;
      end else if (seq_slot) begin
         if (fire) begin
            seq       <= seq + 8'd1;
            e_idx     <= '0;
            pkt_count <= pkt_count + C_ONE;
            if (p_idx == P_LAST) begin
               p_idx   <= '0;
               padding <= 1'b0;
            end else begin
               p_idx <= p_idx + P_ONE;
            end
         end
      end else if (padding || head_data) begin
         if (fire) begin
            if (b_idx == B_LAST) begin
               b_idx <= '0;
               e_idx <= e_idx + E_ONE;
               if (!padding) begin
                  entry_count <= entry_count + C_ONE;
                  if (head[TRIG_BIT] && !trig_seen) begin
                     trig_seen        <= 1'b1;
                     pre_trig_pkts    <= pkt_count;
                     pre_trig_entries <= entry_count;
                  end
               end
            end else begin
               b_idx <= b_idx + B_ONE;
            end
         end
      end else if (head_mark) begin
         if (e_idx != '0 || p_idx != '0) padding <= 1'b1;
      end
   end

   // R9: a stalled byte stays on the output unchanged
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   // R8: padding finishes only on a chunk boundary
   assert_pad_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(padding) |-> (p_idx == '0 && e_idx == '0));

   // R7: trigger latches freeze once set
   assert_trig_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
      trig_seen |=> (trig_seen && $stable(pre_trig_pkts) && $stable(pre_trig_entries)));

   // R7: the pre-trigger packet count never exceeds the packet total
   assert_pre_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      trig_seen |-> (pre_trig_pkts <= pkt_count));
endmodule

// File: rtl/rle_packetizer.sv
module rle_packetizer #(
   parameter int SAMPLE_W        = 16,
   parameter int RUN_W           = 8,
   parameter int ENTRIES_PER_PKT = 5,
   parameter int PKTS_PER_CHUNK  = 5,
   parameter int QUEUE_DEPTH     = 4,
   parameter int CNT_W           = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                smp_valid,
   input  logic [SAMPLE_W-1:0] smp_data,
   input  logic                trig_mark,
   input  logic                flush_req,
   output logic                in_ready,
   output logic [7:0]          out_data,
   output logic                out_valid,
   input  logic                out_ready,
   output logic                trig_seen,
   output logic [CNT_W-1:0]    pre_trig_pkts,
   output logic [CNT_W-1:0]    pre_trig_entries,
   output logic [CNT_W-1:0]    pkt_count,
   output logic [CNT_W-1:0]    entry_count
);
   localparam int EW = SAMPLE_W + RUN_W + 2;

   if (SAMPLE_W < 8 || (SAMPLE_W % 8) != 0) begin : g_chk_sw
      $error("rle_packetizer: SAMPLE_W must be a positive multiple of 8");
   end
   if (RUN_W < 1 || RUN_W > 8) begin : g_chk_rw
      $error("rle_packetizer: RUN_W must lie in 1..8");
   end
   if (ENTRIES_PER_PKT < 1 || PKTS_PER_CHUNK < 1) begin : g_chk_pk
      $error("rle_packetizer: packet and chunk sizes must be at least 1");
   end

   logic          q_push, q_pop, q_empty, q_full;
   logic [EW-1:0] q_in, q_head;

   rle_run_encoder #(.SAMPLE_W(SAMPLE_W), .RUN_W(RUN_W), .EW(EW)) u_enc (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .trig_mark(trig_mark), .flush_req(flush_req), .fifo_full(q_full),
      .in_ready(in_ready), .push(q_push), .push_entry(q_in)
   );

   rle_entry_fifo #(.EW(EW), .DEPTH(QUEUE_DEPTH)) u_q (
      .clk(clk), .rst_n(rst_n), .push(q_push), .push_entry(q_in),
      .pop(q_pop), .head(q_head), .empty(q_empty), .full(q_full)
   );

   rle_byte_framer #(
      .SAMPLE_W(SAMPLE_W), .RUN_W(RUN_W), .EW(EW),
      .ENTRIES_PER_PKT(ENTRIES_PER_PKT), .PKTS_PER_CHUNK(PKTS_PER_CHUNK),
      .CNT_W(CNT_W)
   ) u_frm (
      .clk(clk), .rst_n(rst_n), .head(q_head), .fifo_empty(q_empty),
      .pop(q_pop), .out_data(out_data), .out_valid(out_valid),
      .out_ready(out_ready), .trig_seen(trig_seen),
      .pre_trig_pkts(pre_trig_pkts), .pre_trig_entries(pre_trig_entries),
      .pkt_count(pkt_count), .entry_count(entry_count)
   );
endmodule

// File: tb/rle_packetizer_test.sv
`timescale 1ns/1ps
module rle_packetizer_test;
   localparam int EPP = 5;
   localparam int PPC = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_valid = 1'b0;
   logic [15:0] smp_data = '0;
   logic        trig_mark = 1'b0;
   logic        flush_req = 1'b0;
   logic        in_ready;
   logic [7:0]  out_data;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic        trig_seen;
   logic [15:0] pre_trig_pkts, pre_trig_entries, pkt_count, entry_count;

   always #4 clk = ~clk;

   rle_packetizer uut (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .trig_mark(trig_mark), .flush_req(flush_req), .in_ready(in_ready),
      .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
      .trig_seen(trig_seen), .pre_trig_pkts(pre_trig_pkts),
      .pre_trig_entries(pre_trig_entries), .pkt_count(pkt_count),
      .entry_count(entry_count)
   );

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int zero_cnt_seen = 0;

   logic [7:0] exp_q [$];
   string      tag_q [$];

   bit          m_open = 0, m_trig = 0, m_tseen = 0;
   logic [15:0] m_val;
   int          m_cnt = 0, m_e = 0, m_p = 0, m_pkts = 0, m_ents = 0;
   int          m_pre_p = 0, m_pre_e = 0;
   logic [7:0]  m_seq = 8'd0;

   bit hold_ready = 0, force_ready = 0;
   logic [15:0] lfsr = 16'hACE1;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic m_emit(input logic [15:0] v, input int c, input bit t, input bit pad);
      if (t && !m_tseen) begin
         m_tseen = 1; m_pre_p = m_pkts; m_pre_e = m_ents;
      end
      exp_q.push_back(v[7:0]);  tag_q.push_back(pad ? "R8" : "R1");
      exp_q.push_back(v[15:8]); tag_q.push_back(pad ? "R8" : "R1");
      exp_q.push_back(8'(c));   tag_q.push_back(pad ? "R8" : "R2");
      if (!pad) m_ents++;
      m_e++;
      if (m_e == EPP) begin
         exp_q.push_back(m_seq); tag_q.push_back("R5");
         m_seq = m_seq + 8'd1; m_pkts++; m_e = 0; m_p = (m_p + 1) % PPC;
      end
   endtask

   task automatic m_sample(input logic [15:0] v, input bit t);
      if (m_open && (v != m_val || m_cnt == 255 || t)) begin
         m_emit(m_val, m_cnt, m_trig, 0); m_open = 0;
      end
      if (!m_open) begin
         m_open = 1; m_val = v; m_cnt = 1; m_trig = t;
      end else m_cnt++;
   endtask

   task automatic m_flush();
      if (m_open) begin
         m_emit(m_val, m_cnt, m_trig, 0); m_open = 0;
      end
      while (m_e != 0 || m_p != 0) m_emit(16'h0, 0, 0, 1);
   endtask

   task automatic send(input logic [15:0] v, input bit t);
      @(negedge clk);
      smp_valid = 1'b1; smp_data = v; trig_mark = t;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      m_sample(v, t);
      #1 smp_valid = 1'b0; trig_mark = 1'b0;
   endtask

   task automatic send_run(input logic [15:0] v, input int n);
      for (int i = 0; i < n; i++) send(v, 0);
   endtask

   task automatic flush();
      @(negedge clk);
      flush_req = 1'b1;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      m_flush();
      #1 flush_req = 1'b0;
      @(negedge clk);
      check("R10 in_ready after flush", in_ready, 1'b0);
   endtask

   task automatic drain();
      int n = 0;
      force_ready = 1;
      while (exp_q.size() != 0 && n < 20000) begin
         @(negedge clk); n++;
      end
      repeat (3) @(negedge clk);
      force_ready = 0;
   endtask

   // monitor: chooses out_ready for the coming edge and scores the byte
   always @(negedge clk) begin
      if (rst_n) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         out_ready = hold_ready ? 1'b0 : (force_ready ? 1'b1 : (lfsr[0] | lfsr[1]));
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
               checks++; errors++;
               $display("FAIL R5 unexpected byte actual=%0h expected=none", out_data);
            end else begin
               logic [7:0] e;
               string tg;
               e = exp_q.pop_front();
               tg = tag_q.pop_front();
               if (tg == "R2" && out_data == 8'h00) zero_cnt_seen++;
               check(tg, out_data, e);
            end
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         checks++; errors++;
         $display("FAIL watchdog actual=%0d expected<150000", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int base_pk;
      repeat (4) @(negedge clk);
      // R11 reset state
      check("R11 out_valid", out_valid, 1'b0);
      check("R11 in_ready", in_ready, 1'b1);
      check("R11 trig_seen", trig_seen, 1'b0);
      check("R11 pkt_count", pkt_count, 0);
      check("R11 entry_count", entry_count, 0);
      rst_n = 1'b1;

      // R1 R2: runs of several lengths
      send_run(16'h1234, 3);
      send_run(16'hABCD, 1);
      send_run(16'h00FF, 5);
      send_run(16'h1234, 2);
      // R3: long run split at 255
      send_run(16'h5555, 600);
      // R6: trigger on an unchanged value forces a new entry
      send(16'h5555, 0);
      send(16'h5555, 1);
      send_run(16'h5555, 3);
      // R7: second trigger must not relatch
      send(16'h7777, 1);
      send_run(16'h7777, 2);
      // R8: flush with padding
      flush();
      drain();
      check("R7 trig_seen", trig_seen, 1'b1);
      check("R7 pre_trig_pkts", pre_trig_pkts, m_pre_p);
      check("R6 pre_trig_entries", pre_trig_entries, m_pre_e);
      check("R3 entry_count", entry_count, m_ents);
      check("R8 chunk aligned", pkt_count % PPC, 0);
      check("R12 pkt_count", pkt_count, m_pkts);

      // R8: aligned flush adds no padding
      base_pk = pkt_count;
      for (int i = 0; i < EPP * PPC; i++) send(16'(16'h0100 + i), 0);
      flush();
      drain();
      check("R8 no pad packets", pkt_count - base_pk, PPC);

      // R10: queue full blocks input
      hold_ready = 1;
      for (int i = 0; i < 5; i++) send(16'(16'h2000 + i), 0);
      @(negedge clk);
      check("R10 in_ready when full", in_ready, 1'b0);
      @(negedge clk);
      check("R9 out_valid held", out_valid, 1'b1);
      hold_ready = 0;
      send_run(16'h3000, 4);
      flush();
      drain();

      check("R12 entry_count", entry_count, m_ents);
      check("R12 pkt_count", pkt_count, m_pkts);
      check("R4 zero counts", zero_cnt_seen, 0);
      check("R5 queue empty", exp_q.size(), 0);
      check("R7 latched stays", pre_trig_pkts, m_pre_p);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule